// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects interrupt requests from a set of sources and offers one of them to the processor. Each source owns one byte-wide control register. The register holds a pending flag, a mask bit and a three-bit priority code. A one-cycle pulse on a source's request line sets its pending flag. The flag stays set until the processor acknowledges that source or software clears it. A set mask bit keeps the source from being offered, but its pending flag is kept.

Among the sources that are pending and unmasked, the one with the smallest priority code wins. When codes are equal, the lowest source index wins. The winner is shown as an interrupt request together with its index. Once shown, that index holds until it is acknowledged. On acknowledge, the hardware clears the winner's pending flag.

Software reaches each register over a simple bus. A write can replace the whole byte, or it can change a single chosen bit and leave the other bits alone. Reads are combinational.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Register layout: bit 7 is the pending flag, bit 6 is the mask (1 = blocked), bits 2..0 are the priority code. Bits 5..3 always read 0, so a byte write of 0xFF reads back 0xC7.
- R2: After reset every register reads 0x47 (not pending, masked, code 7) and `irq` is low.
- R3: A one-cycle pulse on `src_req[i]` sets bit 7 of register i. The new value can be read after the next rising clock edge.
- R4: A pending source whose mask bit is 1 does not raise `irq`, and its flag stays set. Clearing the mask bit raises `irq` with that source's index.
- R5: `irq` is high in every cycle in which some source is both pending and unmasked. In that case `irq_idx` names the eligible source with the smallest priority code (code 0 is the most urgent), and equal codes go to the lowest index.
- R6: A cycle with `ack` high while `irq` is high clears the pending flag of the source named by `irq_idx`. The flag reads 0 after that clock edge.
- R7: If there are no bus writes, `irq_idx` keeps its value from one cycle to the next until `ack` is given. This holds even when a more urgent source becomes pending in the meantime.
- R8: A request pulse for a source that arrives in the same cycle as that source's acknowledge leaves the flag set.
- R9: A bus write that changes the pending flag takes precedence over a request pulse for that source in the same cycle. A write that does not touch bit 7 lets the pulse set the flag.
- R10: Writing 1 to bit 7 in software makes the source pending, exactly as a hardware request would.
- R11: Bit mode (`bus_bit` = 1) writes `bus_wdata[0]` into the bit selected by `bus_bitsel` (0..7) and leaves the other bits unchanged. Bit-mode writes to bits 5..3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NSRC | Per-source request pulses |
| ack | input | 1 | Processor acknowledge of the offered source |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_bit | input | 1 | 1 = single-bit write, 0 = whole-byte write |
| bus_bitsel | input | 3 | Bit position for single-bit writes |
| bus_addr | input | IDXW | Register select for reads and writes |
| bus_wdata | input | 8 | Write data (bit 0 only is used in bit mode) |
| bus_rdata | output | 8 | Contents of the register at `bus_addr` |
| irq | output | 1 | Interrupt request to the processor |
| irq_idx | output | IDXW | Index of the offered source |

## Verification
Two updates can reach the same pending flag in the same cycle. A source's own request pulse can coincide with its acknowledge, or with a software write to its register. The bench provokes both collisions by driving the two inputs in the same stimulus cycle. It then reads the register back and samples `irq`, judging that the pulse beats the acknowledge and that a write to bit 7 beats the pulse. It also checks that a single-bit write to the mask field does not stop the pulse from setting the flag.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam int CTRL_W   = 8;
  localparam int PRIO_W   = 3;
  localparam int FLAG_POS = 7;
  localparam int MASK_POS = 6;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h47;

  // Merge a write into a stored control byte.
  function automatic logic [CTRL_W-1:0] merge_write(
    input logic [CTRL_W-1:0] cur,
    input logic              bit_mode,
    input logic [2:0]        bitsel,
    input logic [CTRL_W-1:0] wdata
  );
    logic [CTRL_W-1:0] img;
    img = cur;
    if (bit_mode) img[bitsel] = wdata[0];
    else          img = wdata;
    img[5:3] = 3'b000;
    return img;
  endfunction

  // True when code a is strictly more urgent than code b.
  function automatic logic more_urgent(
    input logic [PRIO_W-1:0] a,
    input logic [PRIO_W-1:0] b
  );
    return a < b;
  endfunction

endpackage

// File: rtl/prio_irq_slot.sv
module prio_irq_slot
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              bit_mode,
  input  logic [2:0]        bitsel,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              hw_set,
  input  logic              hw_clr,
  output logic [CTRL_W-1:0] ctrl_q
);

  logic [CTRL_W-1:0] wr_img;
  logic [CTRL_W-1:0] ctrl_d;
  logic              wr_flag;

  always_comb begin
    wr_img  = merge_write(ctrl_q, bit_mode, bitsel, wdata);
    wr_flag = wr_en && (!bit_mode || bitsel == 3'(FLAG_POS));
    ctrl_d  = wr_en ? wr_img : ctrl_q;
    if (!wr_flag) begin
      if (hw_set)      ctrl_d[FLAG_POS] = 1'b1;
      else if (hw_clr) ctrl_d[FLAG_POS] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr && !hw_set && !wr_en |=> !ctrl_q[FLAG_POS]);

  // R8
  req_over_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set && hw_clr && !wr_en |=> ctrl_q[FLAG_POS]);

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[FLAG_POS] && !wr_en && !hw_clr |=> ctrl_q[FLAG_POS]);

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q[5:3] == 3'b000);

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int IDXW = 3
) (
  input  logic [NSRC-1:0]        elig,
  input  logic [NSRC*PRIO_W-1:0] prio,
  output logic                   any,
  output logic [IDXW-1:0]        win_idx
);

  logic [PRIO_W-1:0] best_p;

  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    best_p  = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!any || more_urgent(prio[i*PRIO_W +: PRIO_W], best_p))) begin
        any     = 1'b1;
        win_idx = IDXW'(i);
        best_p  = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            ack,
  input  logic            bus_wr,
  input  logic            bus_bit,
  input  logic [2:0]      bus_bitsel,
  input  logic [IDXW-1:0] bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic            irq,
  output logic [IDXW-1:0] irq_idx
);

  logic [CTRL_W-1:0]      ctrl [NSRC];
  logic [NSRC-1:0]        elig;
  logic [NSRC-1:0]        hw_clr;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic                   any_elig;
  logic [IDXW-1:0]        win_idx;
  logic                   hold_vld;
  logic [IDXW-1:0]        hold_idx;
  logic                   take_ack;

  assign take_ack = ack && irq;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic wr_sel;
    assign wr_sel    = bus_wr && (bus_addr == IDXW'(i));
    assign hw_clr[i] = take_ack && (irq_idx == IDXW'(i));
    assign elig[i]   = ctrl[i][FLAG_POS] && !ctrl[i][MASK_POS];
    assign prio_flat[i*PRIO_W +: PRIO_W] = ctrl[i][PRIO_W-1:0];

    prio_irq_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_sel),
      .bit_mode (bus_bit),
      .bitsel   (bus_bitsel),
      .wdata    (bus_wdata),
      .hw_set   (src_req[i]),
      .hw_clr   (hw_clr[i]),
      .ctrl_q   (ctrl[i])
    );
  end

  prio_irq_arb #(.NSRC(NSRC), .IDXW(IDXW)) u_arb (
    .elig    (elig),
    .prio    (prio_flat),
    .any     (any_elig),
    .win_idx (win_idx)
  );

  assign irq     = any_elig;
  assign irq_idx = (hold_vld && elig[hold_idx]) ? hold_idx : win_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold_idx <= '0;
    end else begin
      hold_vld <= irq && !ack;
      hold_idx <= irq_idx;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) < NSRC) bus_rdata = ctrl[bus_addr];
  end

  // R5
  win_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> elig[irq_idx]);

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack && !bus_wr |=> irq && $stable(irq_idx));

  // R4
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !ctrl[irq_idx][MASK_POS]);

endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_req = '0;
  logic       ack = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_bit = 1'b0;
  logic [2:0] bus_bitsel = '0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic [2:0] irq_idx;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.NSRC(8)) uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .ack(ack),
    .bus_wr(bus_wr), .bus_bit(bus_bit), .bus_bitsel(bus_bitsel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .irq_idx(irq_idx)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic step(input logic [7:0] req, input logic a, input logic w,
                      input logic bm, input logic [2:0] bs, input logic [2:0] ad,
                      input logic [7:0] d);
    src_req = req; ack = a; bus_wr = w; bus_bit = bm;
    bus_bitsel = bs; bus_addr = ad; bus_wdata = d;
    @(negedge clk);
    src_req = '0; ack = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_byte(input logic [2:0] ad, input logic [7:0] d);
    step(8'h00, 1'b0, 1'b1, 1'b0, 3'd0, ad, d);
  endtask

  task automatic wr_bit(input logic [2:0] ad, input logic [2:0] bs, input logic v);
    step(8'h00, 1'b0, 1'b1, 1'b1, bs, ad, {7'd0, v});
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] ad, input logic [7:0] exp);
    bus_addr = ad;
    #1;
    check(tag, int'(bus_rdata), int'(exp));
  endtask

  task automatic irq_chk(input string tag, input logic ei, input logic [2:0] eidx);
    check({tag, " irq"}, int'(irq), int'(ei));
    if (ei) check({tag, " idx"}, int'(irq_idx), int'(eidx));
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 8; i++) rd_chk("R2 reset value", 3'(i), 8'h47);
    irq_chk("R2 reset", 1'b0, 3'd0);
  endtask

  task automatic t_layout();
    do_reset();
    wr_byte(3'd0, 8'hFF);
    rd_chk("R1 reserved bits", 3'd0, 8'hC7);
    irq_chk("R1 masked", 1'b0, 3'd0);
    wr_byte(3'd0, 8'h00);
    rd_chk("R1 clear", 3'd0, 8'h00);
  endtask

  task automatic t_bitmode();
    do_reset();
    wr_bit(3'd1, 3'd6, 1'b0);
    rd_chk("R11 mask bit", 3'd1, 8'h07);
    wr_bit(3'd1, 3'd4, 1'b1);
    rd_chk("R11 reserved bit", 3'd1, 8'h07);
    wr_bit(3'd1, 3'd1, 1'b0);
    rd_chk("R11 prio bit", 3'd1, 8'h05);
  endtask

  task automatic t_mask();
    do_reset();
    step(8'h08, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    rd_chk("R3 flag set", 3'd3, 8'hC7);
    irq_chk("R4 masked", 1'b0, 3'd0);
    repeat (3) @(negedge clk);
    rd_chk("R4 still pending", 3'd3, 8'hC7);
    wr_bit(3'd3, 3'd6, 1'b0);
    irq_chk("R4 unmasked", 1'b1, 3'd3);
    step(8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    rd_chk("R6 ack clears", 3'd3, 8'h07);
    irq_chk("R6 after ack", 1'b0, 3'd0);
  endtask

  task automatic t_prio();
    do_reset();
    wr_byte(3'd0, 8'h04);
    wr_byte(3'd5, 8'h02);
    wr_byte(3'd6, 8'h02);
    step(8'h61, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    irq_chk("R5 lowest code", 1'b1, 3'd5);
    step(8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    irq_chk("R5 tie next", 1'b1, 3'd6);
    step(8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    irq_chk("R5 last", 1'b1, 3'd0);
    step(8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    irq_chk("R6 drained", 1'b0, 3'd0);
  endtask

  task automatic t_hold();
    do_reset();
    wr_byte(3'd2, 8'h05);
    wr_byte(3'd1, 8'h00);
    step(8'h04, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    irq_chk("R7 first", 1'b1, 3'd2);
    step(8'h02, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    irq_chk("R7 held", 1'b1, 3'd2);
    @(negedge clk);
    irq_chk("R7 still held", 1'b1, 3'd2);
    step(8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    irq_chk("R7 after ack", 1'b1, 3'd1);
  endtask

  task automatic t_race();
    do_reset();
    wr_byte(3'd4, 8'h03);
    step(8'h10, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    irq_chk("R8 pending", 1'b1, 3'd4);
    step(8'h10, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    rd_chk("R8 req beats ack", 3'd4, 8'h83);
    irq_chk("R8 still requesting", 1'b1, 3'd4);
    step(8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    rd_chk("R8 plain ack", 3'd4, 8'h03);
  endtask

  task automatic t_swwin();
    do_reset();
    wr_byte(3'd7, 8'h01);
    step(8'h80, 1'b0, 1'b1, 1'b0, 3'd0, 3'd7, 8'h01);
    rd_chk("R9 byte write wins", 3'd7, 8'h01);
    irq_chk("R9 no irq", 1'b0, 3'd0);
    step(8'h80, 1'b0, 1'b1, 1'b1, 3'd7, 3'd7, 8'h00);
    rd_chk("R9 bit write wins", 3'd7, 8'h01);
    step(8'h80, 1'b0, 1'b1, 1'b1, 3'd6, 3'd7, 8'h00);
    rd_chk("R9 other bit lets req set", 3'd7, 8'h81);
    irq_chk("R9 irq", 1'b1, 3'd7);
  endtask

  task automatic t_swset();
    do_reset();
    wr_byte(3'd2, 8'h83);
    rd_chk("R10 sw set", 3'd2, 8'h83);
    irq_chk("R10 irq", 1'b1, 3'd2);
    wr_bit(3'd5, 3'd6, 1'b0);
    wr_bit(3'd5, 3'd7, 1'b1);
    irq_chk("R10 bit set no preempt", 1'b1, 3'd2);
    step(8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00);
    irq_chk("R10 next", 1'b1, 3'd5);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_layout();
    t_bitmode();
    t_mask();
    t_prio();
    t_hold();
    t_race();
    t_swwin();
    t_swset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule